// File: doc/BRIEF.md
# Flash Read-Margin Level Controller

This block keeps the read-margin setting of a non-volatile memory and presents it as a 3-bit code to the sense-threshold logic. A margin-1 setting raises the read threshold, so an erased cell that has grown weak reads back as 0. A margin-0 setting lowers the threshold, so a programmed cell that has grown weak reads back as 1. Software can read the whole memory under each margin setting to judge data retention. It then returns the setting to normal.

Two commands can change the setting: a user command and a field command. The user command reaches only the normal and user-margin levels. The field command also reaches the stricter field levels, which serve for verifying initial factory programming. Every command is checked against the chip's operating mode and security state. An accepted command replaces the active level. A refused command leaves the active level as it was and raises a sticky access-error flag. Each command is a one-cycle valid pulse, and the block answers it with a one-cycle done pulse.

Top module: `margin_ctrl`

## Requirements
- R1: After reset, `level_out` is 000 (normal), `access_err` is 0 and `cmd_done` is 0.
- R2: Level codes are 000 normal, 001 user margin-1, 010 user margin-0, 011 field margin-1 and 100 field margin-0. A field command (`cmd_field`=1) is accepted only when `mode_special`=1 and `dev_secured`=0. Otherwise it is refused.
- R3: A user command (`cmd_field`=0) with a user-reachable code (000, 001, 010) is accepted in normal mode (`mode_special`=0), whether the device is secured or not.
- R4: A user command is accepted in special mode when the device is unsecured. It is refused in special mode when the device is secured.
- R5: A user command that carries a field code (011 or 100) is refused.
- R6: Codes 101, 110 and 111 are refused by either command.
- R7: An accepted field command can set any of the codes 000 to 100, including the user levels.
- R8: Every `cmd_valid` pulse is answered by `cmd_done` high for exactly the next cycle.
- R9: A refused command leaves `level_out` unchanged and sets `access_err` in the cycle of its `cmd_done`. The flag stays set until `err_clear`=1 is applied. When a refusal and `err_clear` occur in the same cycle, the flag remains set.
- R10: The most recent accepted command alone decides `level_out`. A later user command replaces an earlier field level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | One-cycle command strobe |
| cmd_field | input | 1 | 1 = field command, 0 = user command |
| cmd_level | input | 3 | Requested level code |
| mode_special | input | 1 | 1 = special mode, 0 = normal mode |
| dev_secured | input | 1 | 1 = device secured |
| err_clear | input | 1 | Write-1 clear of the access-error flag |
| level_out | output | 3 | Active level code to the sense-threshold logic |
| cmd_done | output | 1 | One-cycle completion pulse |
| access_err | output | 1 | Sticky access-error flag |

## Verification
The assertions assume that `mode_special` and `dev_secured` stay steady in the cycle where a command is sampled. They also assume that `cmd_valid` is a single-cycle strobe, because the done pulse is checked one cycle behind it. The stimulus sets the mode, security and level inputs on the falling edge together with the strobe. It drops the strobe after one cycle and always waits for the done pulse before sending the next command. Back-to-back commands therefore never overlap.

// File: rtl/nvm_margin_pkg.sv
// Package: shared level-code width and the level encoding, plus reach helpers.
// Assumes: codes above LVL_FIELD_M0 are undefined and must be refused.
package nvm_margin_pkg;
    localparam int LVL_W = 3;

    typedef enum logic [LVL_W-1:0] {
        LVL_NORMAL   = 3'b000,
        LVL_USER_M1  = 3'b001,
        LVL_USER_M0  = 3'b010,
        LVL_FIELD_M1 = 3'b011,
        LVL_FIELD_M0 = 3'b100
    } lvl_e;

    // True for codes a user command may select.
    function automatic logic is_user_lvl(input logic [LVL_W-1:0] c);
        return (c == LVL_NORMAL) || (c == LVL_USER_M1) || (c == LVL_USER_M0);
    endfunction

    // True for the stricter codes only a field command may select.
    function automatic logic is_field_lvl(input logic [LVL_W-1:0] c);
        return (c == LVL_FIELD_M1) || (c == LVL_FIELD_M0);
    endfunction
endpackage

// File: rtl/margin_cmd_check.sv
// Module: combinational permission check for one margin command.
// Assumes: mode and security inputs are stable while a command is sampled.
module margin_cmd_check
    import nvm_margin_pkg::*;
(
    input  logic             cmd_field,
    input  logic [LVL_W-1:0] cmd_level,
    input  logic             mode_special,
    input  logic             dev_secured,
    output logic             grant
);
    logic user_ctx_ok;
    logic field_ctx_ok;

    // Decide whether the context and the code both allow this command.
    always_comb begin
        user_ctx_ok  = !mode_special || !dev_secured;
        field_ctx_ok = mode_special && !dev_secured;
        if (cmd_field)
            grant = field_ctx_ok && (is_user_lvl(cmd_level) || is_field_lvl(cmd_level));
        else
            grant = user_ctx_ok && is_user_lvl(cmd_level);
    end
endmodule

// File: rtl/margin_level_reg.sv
// Module: holds the active level and produces the done pulse.
// Assumes: cmd_valid is a single-cycle strobe; grant is valid with it.
module margin_level_reg
    import nvm_margin_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic             grant,
    input  logic [LVL_W-1:0] cmd_level,
    output logic [LVL_W-1:0] level_q,
    output logic             done_q
);
    // Load a granted level; pulse done for each command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level_q <= LVL_NORMAL;
            done_q  <= 1'b0;
        end else begin
            done_q <= cmd_valid;
            if (cmd_valid && grant)
                level_q <= cmd_level;
        end
    end

    // A refused command must not move the level (R9).
    p_hold_on_refuse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !grant) |=> $stable(level_q));
endmodule

// File: rtl/margin_err_flag.sv
// Module: sticky access-error flag, write-1 clear, set has priority.
// Assumes: set is a single-cycle refusal indication.
module margin_err_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic err_q
);
    // Track the sticky flag; a new refusal wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            err_q <= 1'b0;
        else if (set)
            err_q <= 1'b1;
        else if (clr)
            err_q <= 1'b0;
    end

    // Flag holds while no clear is applied (R9).
    p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (err_q && !clr) |=> err_q);
endmodule

// File: rtl/margin_ctrl.sv
// Module: top of the read-margin level controller. It checks each command
// against mode and security, updates the level or flags an access error.
// Assumes: one command at a time; cmd_valid lasts one cycle.
module margin_ctrl
    import nvm_margin_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic             cmd_field,
    input  logic [LVL_W-1:0] cmd_level,
    input  logic             mode_special,
    input  logic             dev_secured,
    input  logic             err_clear,
    output logic [LVL_W-1:0] level_out,
    output logic             cmd_done,
    output logic             access_err
);
    logic grant;
    logic refuse;

    margin_cmd_check u_check (
        .cmd_field    (cmd_field),
        .cmd_level    (cmd_level),
        .mode_special (mode_special),
        .dev_secured  (dev_secured),
        .grant        (grant)
    );

    margin_level_reg u_level (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .grant     (grant),
        .cmd_level (cmd_level),
        .level_q   (level_out),
        .done_q    (cmd_done)
    );

    // Flag a refusal only on a sampled command.
    always_comb refuse = cmd_valid && !grant;

    margin_err_flag u_err (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (refuse),
        .clr   (err_clear),
        .err_q (access_err)
    );

    // Field command outside special unsecured context is refused (R2).
    p_field_ctx_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_field && !(mode_special && !dev_secured))
        |=> ($stable(level_out) && access_err));

    // User command in normal mode with a user code takes effect (R3).
    p_user_normal_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_field && !mode_special && (cmd_level <= 3'b010))
        |=> (level_out == $past(cmd_level)));

    // User command never reaches field or undefined codes (R5).
    p_user_reach_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_field && (cmd_level >= 3'b011))
        |=> ($stable(level_out) && access_err));

    // Undefined codes are refused by either command (R6).
    p_bad_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && (cmd_level >= 3'b101)) |=> $stable(level_out));

    // Done answers each strobe for exactly one cycle (R8).
    p_done_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> cmd_done);
    p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |=> !cmd_done);

    // Output never carries an undefined code (R2).
    p_level_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
        level_out <= 3'b100);
endmodule

// File: tb/margin_ctrl_tb_top.sv
// Bench: directed scenarios, one task each, each checking its own results.
module margin_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic       cmd_field = 1'b0;
    logic [2:0] cmd_level = 3'b000;
    logic       mode_special = 1'b0;
    logic       dev_secured = 1'b0;
    logic       err_clear = 1'b0;
    logic [2:0] level_out;
    logic       cmd_done;
    logic       access_err;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    margin_ctrl dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmd_valid    (cmd_valid),
        .cmd_field    (cmd_field),
        .cmd_level    (cmd_level),
        .mode_special (mode_special),
        .dev_secured  (dev_secured),
        .err_clear    (err_clear),
        .level_out    (level_out),
        .cmd_done     (cmd_done),
        .access_err   (access_err)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Clear the error flag with a one-cycle write-1 pulse.
    task automatic clear_err();
        @(negedge clk) err_clear = 1'b1;
        @(negedge clk) err_clear = 1'b0;
    endtask

    // Send one command; at return outputs of its done cycle are visible.
    task automatic send(input logic fld, input logic [2:0] lvl,
                        input logic spc, input logic sec);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_field = fld; cmd_level = lvl;
        mode_special = spc; dev_secured = sec;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    // Send, then verify done, level and error; clear afterwards.
    task automatic run_cmd(input string tag, input logic fld, input logic [2:0] lvl,
                           input logic spc, input logic sec,
                           input int exp_lvl, input int exp_err);
        send(fld, lvl, spc, sec);
        check({tag, " done"}, int'(cmd_done), 1);
        check({tag, " level"}, int'(level_out), exp_lvl);
        check({tag, " err"}, int'(access_err), exp_err);
        @(negedge clk);
        check({tag, " done low R8"}, int'(cmd_done), 0);
        if (exp_err != 0) clear_err();
    endtask

    task automatic t_reset();
        check("R1 level", int'(level_out), 0);
        check("R1 err", int'(access_err), 0);
        check("R1 done", int'(cmd_done), 0);
    endtask

    task automatic t_field_ctx();
        run_cmd("R2 field spc unsec", 1'b1, 3'b011, 1'b1, 1'b0, 3, 0);
        run_cmd("R2 field normal", 1'b1, 3'b100, 1'b0, 1'b0, 3, 1);
        run_cmd("R2 field spc sec", 1'b1, 3'b100, 1'b1, 1'b1, 3, 1);
        run_cmd("R2 field normal sec", 1'b1, 3'b000, 1'b0, 1'b1, 3, 1);
        run_cmd("R2 field m0", 1'b1, 3'b100, 1'b1, 1'b0, 4, 0);
    endtask

    task automatic t_user_normal();
        run_cmd("R3 user normal unsec", 1'b0, 3'b001, 1'b0, 1'b0, 1, 0);
        run_cmd("R3 user normal sec", 1'b0, 3'b010, 1'b0, 1'b1, 2, 0);
        run_cmd("R3 user normal sec nrm", 1'b0, 3'b000, 1'b0, 1'b1, 0, 0);
    endtask

    task automatic t_user_special();
        run_cmd("R4 user spc unsec", 1'b0, 3'b010, 1'b1, 1'b0, 2, 0);
        run_cmd("R4 user spc sec", 1'b0, 3'b001, 1'b1, 1'b1, 2, 1);
    endtask

    task automatic t_user_reach();
        run_cmd("R5 user field m1", 1'b0, 3'b011, 1'b1, 1'b0, 2, 1);
        run_cmd("R5 user field m0", 1'b0, 3'b100, 1'b0, 1'b0, 2, 1);
    endtask

    task automatic t_bad_codes();
        for (int c = 5; c < 8; c++) begin
            run_cmd("R6 field bad", 1'b1, 3'(c), 1'b1, 1'b0, 2, 1);
            run_cmd("R6 user bad", 1'b0, 3'(c), 1'b0, 1'b0, 2, 1);
        end
    endtask

    task automatic t_field_user_lvls();
        run_cmd("R7 field user m1", 1'b1, 3'b001, 1'b1, 1'b0, 1, 0);
        run_cmd("R7 field normal", 1'b1, 3'b000, 1'b1, 1'b0, 0, 0);
    endtask

    task automatic t_sticky();
        send(1'b0, 3'b111, 1'b0, 1'b0);
        repeat (3) @(negedge clk);
        check("R9 sticky", int'(access_err), 1);
        check("R9 level kept", int'(level_out), 0);
        clear_err();
        check("R9 cleared", int'(access_err), 0);
        // Refusal together with clear: set wins.
        @(negedge clk);
        cmd_valid = 1'b1; cmd_field = 1'b1; cmd_level = 3'b011;
        mode_special = 1'b0; dev_secured = 1'b0; err_clear = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0; err_clear = 1'b0;
        check("R9 set beats clear", int'(access_err), 1);
        clear_err();
        check("R9 cleared again", int'(access_err), 0);
    endtask

    task automatic t_last_wins();
        run_cmd("R10 field m1", 1'b1, 3'b011, 1'b1, 1'b0, 3, 0);
        run_cmd("R10 user replaces", 1'b0, 3'b010, 1'b0, 1'b1, 2, 0);
        run_cmd("R10 field m0", 1'b1, 3'b100, 1'b1, 1'b0, 4, 0);
        run_cmd("R10 user normal", 1'b0, 3'b000, 1'b1, 1'b0, 0, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_field_ctx();
        t_user_normal();
        t_user_special();
        t_user_reach();
        t_bad_codes();
        t_field_user_lvls();
        t_sticky();
        t_last_wins();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule